// File: doc/BRIEF.md
# Four-Level Modem Task Sequencer

This block is the host-facing control core of a symbol-based modem data pump. The host issues a 3-bit task code through a command port. It learns the block's state from two status flags: a free flag that shows a new task may be written, and an interrupt flag that marks a finished task. An active-low interrupt pin follows the interrupt flag when the host has enabled it. Received symbols, two bits each, stream into an internal symbol store. Each task waits until the store holds the number of symbols that task needs. It then pulses a start strobe to a fixed-latency decode stage, drains those symbols and packs the data symbols into a byte buffer. The host reads that buffer over a valid/ready stream, byte 0 first.

Symbols go on filling the store at all times, so a task can be queued while its own symbols are still arriving. The host reads the previous task's bytes and writes the next task at the same moment. In transmit mode the same codes select send tasks. For those the symbol input acts as the symbol-slot strobe that paces each task, and no bytes are produced. Frame-sync search and error correction are not modelled: a search task consumes a sync-length window of symbols, and the decode stage is a pure delay.

Stream rules: a symbol is taken on a cycle where `sym_valid` and `sym_ready` are both high, and `sym_ready` is low only while the store is full. An output byte is consumed on a cycle where `out_valid` and `out_ready` are both high. While the host holds `out_ready` low, `out_valid` and `out_data` stay steady, unless a transfer for a newer task starts.

Top module: `fsk_task_seq`

## Requirements
- R1: Task codes are decoded with the mode (sampled when the task is accepted). Receive mode: 001 consumes SYNC_SYMS+HDR_SYMS symbols and keeps HDR_SYMS/4 bytes from the symbols after the first SYNC_SYMS. 010 needs HDR_SYMS symbols and gives HDR_SYMS/4 bytes. 011 needs BLK_SYMS symbols and gives BLK_SYMS/4 bytes. 100 consumes SYNC_SYMS symbols and gives no bytes. 101 needs 4 symbols and gives 1 byte. Transmit mode: 001 uses TX_PRE_SYMS symbol slots, 010 uses HDR_SYMS slots, 011 and 100 use BLK_SYMS slots and 101 uses 4 slots.
- R2: A command with code 001 to 101, written while `stat_free` is 1, is accepted, and `stat_free` reads 0 from the next cycle.
- R3: Any command other than 111 written while `stat_free` is 0 is ignored.
- R4: Codes 000 and 110 leave `stat_free` at 1 and do not raise `stat_irq`.
- R5: An accepted task waits until the store holds at least its symbol count. It then drives `dec_start` high for one cycle and stays busy for DEC_LAT cycles. After that it removes its symbols from the store, one per cycle.
- R6: On the cycle that moves a task's last symbol out of the store, `stat_free` and `stat_irq` both rise together.
- R7: `irq_n` is low exactly when `stat_irq` is 1 and `irq_enable` is 1.
- R8: A `stat_rd` pulse clears `stat_irq` on the next cycle, unless a task finishes on that same edge.
- R9: Code 111 takes effect in any state. It sets `stat_free` to 1, empties the symbol store and drops the running task without raising `stat_irq`.
- R10: Output byte k carries data symbols 4k to 4k+3, symbol 4k+m in bits [2m+1:2m]. Bytes come out in index order from 0. Bytes left over from an earlier task are withdrawn when the next transfer starts.
- R11: Symbols are stored while the block is free or busy. `sym_ready` falls only when the store holds STORE_DEPTH symbols.
- R12: Tasks run in transmit mode put no bytes in the buffer, so `out_valid` stays 0 after they finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_tx | input | 1 | 1 selects transmit task decoding |
| irq_enable | input | 1 | Lets the interrupt flag drive `irq_n` |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 3 | Task code |
| stat_rd | input | 1 | Status read strobe, clears the interrupt flag |
| stat_free | output | 1 | Free flag: a new task may be written |
| stat_irq | output | 1 | Interrupt flag: a task has finished |
| irq_n | output | 1 | Active-low interrupt request |
| sym_valid | input | 1 | Symbol stream valid |
| sym_ready | output | 1 | Symbol stream ready (store not full) |
| sym_data | input | 2 | Received four-level symbol |
| dec_start | output | 1 | One-cycle start strobe to the decode stage |
| out_valid | output | 1 | Output byte stream valid |
| out_ready | input | 1 | Output byte stream ready |
| out_data | output | 8 | Output byte |

## Verification
The bench goes after four cases: a task written while the symbols it needs are already stored, a second task written while the first is still waiting, a reset command in the middle of a task, and a store filled to capacity. A design that counted symbols only after a task was accepted would stall in the first case. One that honoured busy-time commands would produce eight bytes where four are due. One that let the reset path raise the interrupt, or left stale symbols behind, would set the flag or feed old data into the next task. The packing of symbols into bits is pinned down with a hand-computed byte, and the two search and transmit cases check that no bytes appear.

// File: rtl/fsk_seq_pkg.sv
package fsk_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DEC  = 2'd2,
    ST_XFER = 2'd3
  } seq_state_e;

  localparam logic [2:0] CODE_NULL_LO = 3'd0;
  localparam logic [2:0] CODE_NULL_HI = 3'd6;
  localparam logic [2:0] CODE_ABORT   = 3'd7;
endpackage

// File: rtl/fsk_task_table.sv
module fsk_task_table #(
  parameter int SYNC_SYMS   = 24,
  parameter int HDR_SYMS    = 16,
  parameter int BLK_SYMS    = 32,
  parameter int TX_PRE_SYMS = 24,
  parameter int CW          = 7,
  parameter int NBW         = 4
) (
  input  logic [2:0]     code,
  input  logic           tx,
  output logic           runs,
  output logic [CW-1:0]  thr,
  output logic [CW-1:0]  skip,
  output logic [NBW-1:0] nbytes
);
  always_comb begin
    runs   = 1'b1;
    thr    = '0;
    skip   = '0;
    nbytes = '0;
    unique case (code)
      3'd1: begin
        if (tx) begin
          thr  = CW'(TX_PRE_SYMS);
          skip = CW'(TX_PRE_SYMS);
        end else begin
          thr    = CW'(SYNC_SYMS + HDR_SYMS);
          skip   = CW'(SYNC_SYMS);
          nbytes = NBW'(HDR_SYMS / 4);
        end
      end
      3'd2: begin
        thr = CW'(HDR_SYMS);
        if (tx) skip = CW'(HDR_SYMS);
        else    nbytes = NBW'(HDR_SYMS / 4);
      end
      3'd3: begin
        thr = CW'(BLK_SYMS);
        if (tx) skip = CW'(BLK_SYMS);
        else    nbytes = NBW'(BLK_SYMS / 4);
      end
      3'd4: begin
        if (tx) begin
          thr  = CW'(BLK_SYMS);
          skip = CW'(BLK_SYMS);
        end else begin
          thr  = CW'(SYNC_SYMS);
          skip = CW'(SYNC_SYMS);
        end
      end
      3'd5: begin
        thr = CW'(4);
        if (tx) skip = CW'(4);
        else    nbytes = NBW'(1);
      end
      default: runs = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsk_sym_store.sv
module fsk_sym_store #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [1:0]    din,
  input  logic          pop,
  output logic [1:0]    dout,
  output logic [CW-1:0] count,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop)     rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop);
    end
  end
endmodule

// File: rtl/fsk_dec_stub.sv
module fsk_dec_stub #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  output logic done
);
  localparam int LW = $clog2(LAT + 1);

  logic          busy;
  logic [LW-1:0] left;

  assign done = busy && (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      left <= '0;
    end else if (start) begin
      busy <= 1'b1;
      left <= LW'(LAT - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/fsk_task_seq.sv
module fsk_task_seq
  import fsk_seq_pkg::*;
#(
  parameter int SYNC_SYMS   = 24,
  parameter int HDR_SYMS    = 16,
  parameter int BLK_SYMS    = 32,
  parameter int TX_PRE_SYMS = 24,
  parameter int STORE_DEPTH = 64,
  parameter int DEC_LAT     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_tx,
  input  logic       irq_enable,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       stat_rd,
  output logic       stat_free,
  output logic       stat_irq,
  output logic       irq_n,
  input  logic       sym_valid,
  output logic       sym_ready,
  input  logic [1:0] sym_data,
  output logic       dec_start,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int CW        = $clog2(STORE_DEPTH + 1);
  localparam int MAX_DATA  = (HDR_SYMS > BLK_SYMS) ? HDR_SYMS : BLK_SYMS;
  localparam int BUF_BYTES = MAX_DATA / 4;
  localparam int NBW       = $clog2(BUF_BYTES + 1);
  localparam int PW        = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;

  seq_state_e     state;
  logic           free_q, irq_q;
  logic [CW-1:0]  thr_q, skip_q, xfer_idx;
  logic [NBW-1:0] nb_q, blen_q, rptr_q;
  logic [7:0]     buf_q [BUF_BYTES];

  logic           tbl_runs;
  logic [CW-1:0]  tbl_thr, tbl_skip;
  logic [NBW-1:0] tbl_nb;
  logic [CW-1:0]  store_cnt;
  logic           store_full;
  logic [1:0]     store_dout;
  logic           dec_done;

  logic abort, accept, pop, last, finish, in_data;
  logic [CW-1:0] didx;

  fsk_task_table #(
    .SYNC_SYMS(SYNC_SYMS), .HDR_SYMS(HDR_SYMS), .BLK_SYMS(BLK_SYMS),
    .TX_PRE_SYMS(TX_PRE_SYMS), .CW(CW), .NBW(NBW)
  ) u_table (
    .code(cmd_code), .tx(mode_tx), .runs(tbl_runs),
    .thr(tbl_thr), .skip(tbl_skip), .nbytes(tbl_nb)
  );

  fsk_sym_store #(.DEPTH(STORE_DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(abort),
    .push(sym_valid), .din(sym_data), .pop(pop),
    .dout(store_dout), .count(store_cnt), .full(store_full)
  );

  fsk_dec_stub #(.LAT(DEC_LAT)) u_dec (
    .clk(clk), .rst_n(rst_n), .abort(abort),
    .start(dec_start), .done(dec_done)
  );

  assign abort     = cmd_valid && (cmd_code == CODE_ABORT);
  assign accept    = cmd_valid && free_q && tbl_runs && !abort;
  assign dec_start = (state == ST_WAIT) && (store_cnt >= thr_q) && !abort;
  assign pop       = (state == ST_XFER) && !abort;
  assign last      = (xfer_idx == thr_q - 1'b1);
  assign finish    = pop && last;
  assign in_data   = (xfer_idx >= skip_q);
  assign didx      = xfer_idx - skip_q;

  assign sym_ready = !store_full;
  assign stat_free = free_q;
  assign stat_irq  = irq_q;
  assign irq_n     = !(irq_q && irq_enable);
  assign out_valid = (rptr_q < blen_q);
  assign out_data  = buf_q[rptr_q[PW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      free_q   <= 1'b1;
      thr_q    <= '0;
      skip_q   <= '0;
      nb_q     <= '0;
      xfer_idx <= '0;
    end else if (abort) begin
      state  <= ST_IDLE;
      free_q <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_WAIT;
          free_q <= 1'b0;
          thr_q  <= tbl_thr;
          skip_q <= tbl_skip;
          nb_q   <= tbl_nb;
        end
        ST_WAIT: if (dec_start) state <= ST_DEC;
        ST_DEC: if (dec_done) begin
          state    <= ST_XFER;
          xfer_idx <= '0;
        end
        ST_XFER: begin
          if (last) begin
            state  <= ST_IDLE;
            free_q <= 1'b1;
          end else begin
            xfer_idx <= xfer_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (finish)  irq_q <= 1'b1;
    else if (stat_rd) irq_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= '0;
      rptr_q <= '0;
    end else begin
      if (finish) begin
        blen_q <= nb_q;
        rptr_q <= '0;
      end else begin
        if (state == ST_DEC && dec_done && !abort) blen_q <= '0;
        if (out_valid && out_ready) rptr_q <= rptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
    end else if (pop && in_data && (didx[CW-1:2] < (CW-2)'(BUF_BYTES))) begin
      buf_q[didx[PW+1:2]][{didx[1:0], 1'b0} +: 2] <= store_dout;
    end
  end
endmodule

// File: rtl/fsk_task_seq_chk.sv
module fsk_task_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_enable,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       stat_rd,
  input logic       stat_free,
  input logic       stat_irq,
  input logic       irq_n,
  input logic       dec_start,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data
);
  logic real_task;
  assign real_task = (cmd_code >= 3'd1) && (cmd_code <= 3'd5);

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && stat_free && real_task) |=> !stat_free);

  assert_null_stays_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && stat_free && (cmd_code == 3'd0 || cmd_code == 3'd6))
      |=> (stat_free && !$rose(stat_irq)));

  assert_start_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start |-> !stat_free);

  assert_irq_with_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_irq) |-> $rose(stat_free));

  assert_pin_follows_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (stat_irq && irq_enable));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && stat_free) |=> !stat_irq);

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd7) |=> (stat_free && !$rose(stat_irq)));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && stat_free) |=> (out_valid && $stable(out_data)));
endmodule

bind fsk_task_seq fsk_task_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_enable(irq_enable),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .stat_rd(stat_rd),
  .stat_free(stat_free), .stat_irq(stat_irq), .irq_n(irq_n),
  .dec_start(dec_start), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/fsk_task_seq_test.sv
module fsk_task_seq_test;
  localparam int SYNC = 24, HDR = 16, BLK = 32, TXP = 24, DEPTH = 64, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_tx = 0, ien = 0, cv = 0, srd = 0, sv = 0, ordy = 0;
  logic [2:0] code = 0;
  logic [1:0] sd = 0;
  logic stat_free, stat_irq, irq_n, sym_ready, dec_start, out_valid;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  fsk_task_seq #(.SYNC_SYMS(SYNC), .HDR_SYMS(HDR), .BLK_SYMS(BLK),
    .TX_PRE_SYMS(TXP), .STORE_DEPTH(DEPTH), .DEC_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .irq_enable(ien),
    .cmd_valid(cv), .cmd_code(code), .stat_rd(srd),
    .stat_free(stat_free), .stat_irq(stat_irq), .irq_n(irq_n),
    .sym_valid(sv), .sym_ready(sym_ready), .sym_data(sd),
    .dec_start(dec_start), .out_valid(out_valid), .out_ready(ordy),
    .out_data(out_data));

  int tests = 0, fails = 0, cycles = 0;

  // ---------------- behavioural reference model ----------------
  int q[$];
  int ms = 0, mthr = 0, mskip = 0, mnb = 0, mlat = 0, midx = 0;
  int mbuf[8];
  int mblen = 0, mrptr = 0;
  bit mfree = 1, mirq = 0, lastpush = 0;

  task automatic lookup(input int c, input bit tx, output int t, output int s, output int n);
    t = 0; s = 0; n = 0;
    case (c)
      1: if (tx) begin t = TXP; s = TXP; end else begin t = SYNC + HDR; s = SYNC; n = HDR / 4; end
      2: begin t = HDR; if (tx) s = HDR; else n = HDR / 4; end
      3: begin t = BLK; if (tx) s = BLK; else n = BLK / 4; end
      4: if (tx) begin t = BLK; s = BLK; end else begin t = SYNC; s = SYNC; end
      5: begin t = 4; if (tx) s = 4; else n = 1; end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); ms = 0; mfree = 1; mirq = 0; mblen = 0; mrptr = 0; lastpush = 0;
    end else begin
      bit abort, push, fin;
      abort = cv && code == 3'd7;
      push = sv && q.size() < DEPTH;
      lastpush = push;
      fin = 0;
      if (mrptr < mblen && ordy) mrptr++;
      if (abort) begin
        q.delete(); ms = 0; mfree = 1;
      end else begin
        case (ms)
          0: if (cv && mfree && code >= 1 && code <= 5) begin
               lookup(code, mode_tx, mthr, mskip, mnb); ms = 1; mfree = 0;
             end
          1: if (q.size() >= mthr) begin ms = 2; mlat = LAT; end
          2: if (mlat == 1) begin ms = 3; midx = 0; mblen = 0; end else mlat--;
          3: begin
               int s, j;
               s = q.pop_front();
               if (midx >= mskip) begin
                 j = midx - mskip;
                 mbuf[j / 4] = (mbuf[j / 4] & ~(3 << (2 * (j % 4)))) | (s << (2 * (j % 4)));
               end
               if (midx == mthr - 1) begin
                 ms = 0; mfree = 1; fin = 1; mblen = mnb; mrptr = 0;
               end else midx++;
             end
          default: ;
        endcase
        if (push) q.push_back(int'(sd));
      end
      if (fin) mirq = 1; else if (srd) mirq = 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    bit m_start, ok;
    m_start = (ms == 1) && (q.size() >= mthr) && !(cv && code == 3'd7);
    ok = 1;
    if (stat_free !== mfree) begin ok = 0; $display("FAIL R6 free actual=%0d expected=%0d", stat_free, mfree); end
    if (stat_irq !== mirq) begin ok = 0; $display("FAIL R8 irq actual=%0d expected=%0d", stat_irq, mirq); end
    if (irq_n !== !(mirq && ien)) begin ok = 0; $display("FAIL R7 irq_n actual=%0d expected=%0d", irq_n, !(mirq && ien)); end
    if (sym_ready !== (q.size() < DEPTH)) begin ok = 0; $display("FAIL R11 ready actual=%0d expected=%0d", sym_ready, q.size() < DEPTH); end
    if (dec_start !== m_start) begin ok = 0; $display("FAIL R5 start actual=%0d expected=%0d", dec_start, m_start); end
    if (out_valid !== (mrptr < mblen)) begin ok = 0; $display("FAIL R10 valid actual=%0d expected=%0d", out_valid, mrptr < mblen); end
    else if (out_valid && out_data !== 8'(mbuf[mrptr])) begin ok = 0; $display("FAIL R10 data actual=%0d expected=%0d", out_data, mbuf[mrptr]); end
    tests++;
    if (!ok) fails++;
  endtask

  bit gen_on = 0;
  int k = 0;

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) compare_all();
      if (gen_on) begin
        if (lastpush) k++;
        sd = 2'((k * 7 + k / 3) % 4);
      end
    end
  endtask

  task automatic send(input logic [2:0] c);
    cv = 1; code = c; cyc(); cv = 0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400 && !stat_irq; i++) cyc();
  endtask

  task automatic drain(output int n);
    n = 0;
    ordy = 1;
    for (int i = 0; i < 12; i++) begin
      if (out_valid) n++;
      cyc();
    end
    ordy = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 8; i++) mbuf[i] = 0;
    cyc(3);
    rst_n = 1;
    cyc();
    chk(stat_free === 1 && stat_irq === 0 && irq_n === 1 && out_valid === 0 && sym_ready === 1,
        "R6 reset state", stat_free, 1);

    // NULL codes
    send(3'd0); cyc();
    chk(stat_free === 1 && stat_irq === 0, "R4 code 000", stat_free, 1);
    send(3'd6); cyc();
    chk(stat_free === 1 && stat_irq === 0, "R4 code 110", stat_free, 1);

    // four symbols stored before the task is written
    ien = 1;
    sv = 1; sd = 2'd1; cyc(); sd = 2'd2; cyc(); sd = 2'd3; cyc(); sd = 2'd0; cyc(); sv = 0;
    send(3'd5);
    chk(stat_free === 0, "R2 accepted task busy", stat_free, 0);
    wait_irq();
    chk(stat_irq === 1 && stat_free === 1, "R6 finish flags", stat_irq, 1);
    chk(irq_n === 0, "R7 pin low when enabled", irq_n, 0);
    chk(out_valid === 1 && out_data === 8'h39, "R10 packing byte0", out_data, 8'h39);
    ordy = 1; cyc(); ordy = 0;
    chk(out_valid === 0, "R1 read-4 gives one byte", out_valid, 0);
    srd = 1; cyc(); srd = 0;
    chk(stat_irq === 0 && irq_n === 1, "R8 read clears irq", stat_irq, 0);

    // overlapping tasks with a busy-time command
    gen_on = 1; sv = 1;
    send(3'd2);
    cyc(2);
    send(3'd3);
    chk(stat_free === 0, "R3 busy command ignored", stat_free, 0);
    wait_irq();
    srd = 1; cyc(); srd = 0;
    send(3'd3);
    drain(n);
    chk(n == HDR / 4, "R3 header byte count", n, HDR / 4);
    ien = 0;
    wait_irq();
    chk(irq_n === 1 && stat_irq === 1, "R7 pin masked", irq_n, 1);
    drain(n);
    chk(n == BLK / 4, "R1 block byte count", n, BLK / 4);
    srd = 1; cyc(); srd = 0;

    // search with header, then plain search
    ien = 1;
    send(3'd1); wait_irq(); srd = 1; cyc(); srd = 0;
    drain(n);
    chk(n == HDR / 4, "R1 search+header bytes", n, HDR / 4);
    send(3'd4); wait_irq(); srd = 1; cyc(); srd = 0;
    chk(out_valid === 0, "R1 search gives no bytes", out_valid, 0);

    // fill the store, then abort
    cyc(DEPTH + 8);
    chk(sym_ready === 0, "R11 store full", sym_ready, 0);
    sv = 0;
    send(3'd2);
    cyc(1);
    send(3'd7);
    chk(stat_free === 1 && stat_irq === 0 && sym_ready === 1, "R9 abort mid task", stat_free, 1);
    cyc(LAT + 4);
    chk(stat_irq === 0 && stat_free === 1, "R9 no late finish", stat_irq, 0);

    // transmit mode
    mode_tx = 1; sv = 1;
    send(3'd1); wait_irq();
    chk(stat_irq === 1 && out_valid === 0, "R12 tx preamble no bytes", out_valid, 0);
    srd = 1; cyc(); srd = 0;
    send(3'd4); wait_irq();
    chk(stat_irq === 1 && out_valid === 0, "R12 tx last block no bytes", out_valid, 0);
    sv = 0;
    cyc(4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule